// File: doc/BRIEF.md
# Vector Narrowing Shift Packer

This block takes two vectors of wide integer elements, one called the even vector and one called the odd vector, and a single shift amount that applies to every lane. Each element is shifted right and then brought down to half its width. The reduction either drops the upper bits or clamps the value to the range of the narrower type. Rounding to nearest can be added when clamping is on. The narrowed elements are written into one output vector that is the same width as an input vector, because it holds twice as many elements of half the size.

Two output layouts are available. The interleaved layout puts each even result beside the odd result from the same lane, so every wide slot of the output holds one pair. The split layout puts all even results in the lower half of the output and all odd results in the upper half. The element width is set by a parameter: 32 bits narrowed to 16, or 16 bits narrowed to 8. The datapath has two pipeline stages. The first stage shifts and rounds, and the second stage clamps or truncates and then packs. A valid flag moves through the pipeline with the data.

Lane k of an input vector occupies bits [k*SRC_W +: SRC_W]. Narrow slot j of the output occupies bits [j*DST_W +: DST_W], where DST_W = SRC_W/2.

Top module: `narrow_shift_packer`

## Requirements
- R1: While reset is asserted and after it is released, `vld_out` is low and `dout` is all zeros until the first result arrives.
- R2: A vector accepted with `vld_in` high at a rising edge produces `vld_out` high for exactly one cycle, two rising edges later. While `vld_out` is low, `dout` keeps its last value.
- R3: Every lane is shifted right by `shamt` modulo SRC_W. The shift is arithmetic when `src_signed`=1 and logical when `src_signed`=0.
- R4: With `sat_en`=0, each narrowed result is the low DST_W bits of the shifted value.
- R5: With `sat_en`=1, the shifted value is clamped to [-2^(DST_W-1), 2^(DST_W-1)-1] for a signed destination, or to [0, 2^DST_W-1] for an unsigned destination.
- R6: When `src_signed`=0, the destination is unsigned whatever the value of `dst_signed`.
- R7: With `sat_en`=1, `rnd_en`=1 and a nonzero effective shift s, 2^(s-1) is added before the shift. The sum is formed with enough headroom that it never wraps, even for all-ones inputs.
- R8: `rnd_en` has no effect when `sat_en`=0.
- R9: With `shuf_en`=1, narrow slot 2k holds the even result of lane k and slot 2k+1 holds the odd result of lane k.
- R10: With `shuf_en`=0, slots 0..LANES-1 hold the even results of lanes 0..LANES-1, and slots LANES..2*LANES-1 hold the odd results in the same lane order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vld_in | input | 1 | Input vectors and controls are valid |
| odd_in | input | LANES*SRC_W | Odd source vector |
| even_in | input | LANES*SRC_W | Even source vector |
| shamt | input | SHAMT_W | Right shift amount shared by all lanes, used modulo SRC_W |
| src_signed | input | 1 | 1 = source elements are signed |
| dst_signed | input | 1 | 1 = destination is signed (only takes effect with a signed source) |
| sat_en | input | 1 | 1 = clamp to the destination range, 0 = truncate |
| rnd_en | input | 1 | 1 = round to nearest (only takes effect with sat_en) |
| shuf_en | input | 1 | 1 = interleaved layout, 0 = split layout |
| vld_out | output | 1 | dout carries a new result |
| dout | output | LANES*SRC_W | Packed narrowed vector |

## Verification
The hardest case to reach is a rounding addition that carries beyond the source width. This only happens when an element sits at or near the top of the unsigned source range and rounding is enabled with a small shift. A datapath that is only one bit wider than the source would wrap that sum to a small value instead of clamping it to the maximum. The stimulus drives all-ones unsigned elements and the largest signed element with rounding and a shift of 1, and compares the clamped results. The rest of the stimulus covers both layouts, shift amounts at and above the element width, back-to-back valid inputs, and random vectors, all checked against a behavioural integer model.

// File: rtl/nsp_pkg.sv
package nsp_pkg;
  typedef struct packed {
    logic dst_s;
    logic sat;
    logic shuf;
  } nsp_mode_t;
endpackage

// File: rtl/nsp_shift.sv
module nsp_shift #(
  parameter int SRC_W = 32,
  parameter int SH_W  = $clog2(SRC_W),
  parameter int W2    = SRC_W + 2
) (
  input  logic [SRC_W-1:0] x,
  input  logic [SH_W-1:0]  sh,
  input  logic             src_s,
  input  logic             rnd_en,
  output logic [W2-1:0]    y
);
  logic [W2-1:0] ext;
  logic [W2-1:0] bias;
  logic [W2-1:0] sum;

  always_comb begin
    ext  = src_s ? {{2{x[SRC_W-1]}}, x} : {2'b00, x};
    bias = (rnd_en && (sh != '0)) ? (W2'(1) << (sh - SH_W'(1))) : '0;
    sum  = ext + bias;
    y    = $signed(sum) >>> sh;
  end
endmodule

// File: rtl/nsp_narrow.sv
module nsp_narrow #(
  parameter int SRC_W = 32,
  parameter int DST_W = SRC_W / 2,
  parameter int W2    = SRC_W + 2
) (
  input  logic [W2-1:0]    v,
  input  logic             sat,
  input  logic             dst_s,
  output logic [DST_W-1:0] n
);
  localparam logic signed [W2-1:0] SMAX = W2'((1 << (DST_W - 1)) - 1);
  localparam logic signed [W2-1:0] SMIN = -SMAX - W2'(1);
  localparam logic signed [W2-1:0] UMAX = W2'((1 << DST_W) - 1);

  logic signed [W2-1:0] sv;
  logic signed [W2-1:0] lo;
  logic signed [W2-1:0] hi;

  always_comb begin
    sv = $signed(v);
    lo = dst_s ? SMIN : '0;
    hi = dst_s ? SMAX : UMAX;
    if (!sat)          n = v[DST_W-1:0];
    else if (sv > hi)  n = hi[DST_W-1:0];
    else if (sv < lo)  n = lo[DST_W-1:0];
    else               n = v[DST_W-1:0];
  end
endmodule

// File: rtl/nsp_pack.sv
module nsp_pack #(
  parameter int LANES = 4,
  parameter int DST_W = 16,
  parameter int OW    = 2 * LANES * DST_W
) (
  input  logic [LANES*DST_W-1:0] even_n,
  input  logic [LANES*DST_W-1:0] odd_n,
  input  logic                   shuf,
  output logic [OW-1:0]          packed_o
);
  logic [OW-1:0] inter;
  logic [OW-1:0] split;

  for (genvar k = 0; k < LANES; k++) begin : g_pair
    assign inter[(2*k)*DST_W +: DST_W]   = even_n[k*DST_W +: DST_W];
    assign inter[(2*k+1)*DST_W +: DST_W] = odd_n[k*DST_W +: DST_W];
  end

  assign split    = {odd_n, even_n};
  assign packed_o = shuf ? inter : split;
endmodule

// File: rtl/narrow_shift_packer.sv
module narrow_shift_packer
  import nsp_pkg::*;
#(
  parameter int SRC_W   = 32,
  parameter int LANES   = 4,
  parameter int SHAMT_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   vld_in,
  input  logic [LANES*SRC_W-1:0] odd_in,
  input  logic [LANES*SRC_W-1:0] even_in,
  input  logic [SHAMT_W-1:0]     shamt,
  input  logic                   src_signed,
  input  logic                   dst_signed,
  input  logic                   sat_en,
  input  logic                   rnd_en,
  input  logic                   shuf_en,
  output logic                   vld_out,
  output logic [LANES*SRC_W-1:0] dout
);
  localparam int DST_W = SRC_W / 2;
  localparam int SH_W  = $clog2(SRC_W);
  localparam int W2    = SRC_W + 2;
  localparam int VW    = LANES * SRC_W;
  localparam int SW    = LANES * W2;
  localparam int NW    = LANES * DST_W;

  logic [SH_W-1:0] sh;
  logic            rnd_eff;
  logic [SW-1:0]   even_sh, odd_sh;

  logic [SW-1:0]   s1_even_d, s1_even_q, s1_odd_d, s1_odd_q;
  nsp_mode_t       s1_mode_d, s1_mode_q;
  logic            s1_vld_q;

  logic [NW-1:0]   even_n, odd_n;
  logic [VW-1:0]   packed_w;
  logic [VW-1:0]   dout_d;

  assign sh      = SH_W'(shamt % SHAMT_W'(SRC_W));
  assign rnd_eff = sat_en & rnd_en;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    nsp_shift #(.SRC_W(SRC_W), .SH_W(SH_W), .W2(W2)) u_sh_e (
      .x(even_in[k*SRC_W +: SRC_W]), .sh(sh), .src_s(src_signed),
      .rnd_en(rnd_eff), .y(even_sh[k*W2 +: W2]));
    nsp_shift #(.SRC_W(SRC_W), .SH_W(SH_W), .W2(W2)) u_sh_o (
      .x(odd_in[k*SRC_W +: SRC_W]), .sh(sh), .src_s(src_signed),
      .rnd_en(rnd_eff), .y(odd_sh[k*W2 +: W2]));
    nsp_narrow #(.SRC_W(SRC_W), .DST_W(DST_W), .W2(W2)) u_nr_e (
      .v(s1_even_q[k*W2 +: W2]), .sat(s1_mode_q.sat),
      .dst_s(s1_mode_q.dst_s), .n(even_n[k*DST_W +: DST_W]));
    nsp_narrow #(.SRC_W(SRC_W), .DST_W(DST_W), .W2(W2)) u_nr_o (
      .v(s1_odd_q[k*W2 +: W2]), .sat(s1_mode_q.sat),
      .dst_s(s1_mode_q.dst_s), .n(odd_n[k*DST_W +: DST_W]));
  end

  nsp_pack #(.LANES(LANES), .DST_W(DST_W), .OW(VW)) u_pack (
    .even_n(even_n), .odd_n(odd_n), .shuf(s1_mode_q.shuf), .packed_o(packed_w));

  // Next-state logic
  always_comb begin
    s1_even_d = s1_even_q;
    s1_odd_d  = s1_odd_q;
    s1_mode_d = s1_mode_q;
    if (vld_in) begin
      s1_even_d       = even_sh;
      s1_odd_d        = odd_sh;
      s1_mode_d.dst_s = dst_signed & src_signed;
      s1_mode_d.sat   = sat_en;
      s1_mode_d.shuf  = shuf_en;
    end
    dout_d = s1_vld_q ? packed_w : dout;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q  <= 1'b0;
      s1_even_q <= '0;
      s1_odd_q  <= '0;
      s1_mode_q <= '0;
      vld_out   <= 1'b0;
      dout      <= '0;
    end else begin
      s1_vld_q  <= vld_in;
      s1_even_q <= s1_even_d;
      s1_odd_q  <= s1_odd_d;
      s1_mode_q <= s1_mode_d;
      vld_out   <= s1_vld_q;
      dout      <= dout_d;
    end
  end
endmodule

// File: rtl/nsp_chk.sv
module nsp_chk #(
  parameter int DW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vld_in,
  input logic          vld_out,
  input logic [DW-1:0] dout
);
  // R1
  rst_clear_chk: assert property (@(posedge clk) !rst_n |-> (!vld_out && dout == '0));

  // R2
  lat_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_in |-> ##2 vld_out);

  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_in |-> ##2 !vld_out);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_out |=> (vld_out || $stable(dout)));
endmodule

bind narrow_shift_packer nsp_chk #(.DW(LANES*SRC_W)) u_nsp_chk (
  .clk(clk), .rst_n(rst_n), .vld_in(vld_in), .vld_out(vld_out), .dout(dout));

// File: tb/narrow_shift_packer_test.sv
module narrow_shift_packer_test;
  localparam int SRC_W = 32;
  localparam int LANES = 4;
  localparam int D     = SRC_W / 2;
  localparam int VW    = LANES * SRC_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld_in = 1'b0;
  logic [VW-1:0] odd_in = '0, even_in = '0;
  logic [7:0] shamt = '0;
  logic src_signed = 0, dst_signed = 0, sat_en = 0, rnd_en = 0, shuf_en = 0;
  logic vld_out;
  logic [VW-1:0] dout;

  int total = 0, bad = 0;
  bit done = 0;
  string cur_tag = "R2";

  always #10 clk = ~clk;

  narrow_shift_packer #(.SRC_W(SRC_W), .LANES(LANES), .SHAMT_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .vld_in(vld_in), .odd_in(odd_in), .even_in(even_in),
    .shamt(shamt), .src_signed(src_signed), .dst_signed(dst_signed), .sat_en(sat_en),
    .rnd_en(rnd_en), .shuf_en(shuf_en), .vld_out(vld_out), .dout(dout));

  function automatic logic [D-1:0] ref_lane(logic [SRC_W-1:0] x, bit ss, bit ds,
                                            bit sat, bit rnd, int sh);
    longint v, lo, hi;
    if (ss && x[SRC_W-1]) v = longint'(x) - (longint'(1) << SRC_W);
    else v = longint'(x);
    if (sat && rnd && sh > 0) v = v + (longint'(1) << (sh - 1));
    v = v >>> sh;
    if (sat) begin
      if (ds && ss) begin
        hi = (longint'(1) << (D - 1)) - 1;
        lo = -hi - 1;
      end else begin
        hi = (longint'(1) << D) - 1;
        lo = 0;
      end
      if (v > hi) v = hi;
      if (v < lo) v = lo;
    end
    return v[D-1:0];
  endfunction

  function automatic logic [VW-1:0] ref_out(logic [VW-1:0] o, logic [VW-1:0] e, int sa,
                                            bit ss, bit ds, bit sat, bit rnd, bit shuf);
    logic [VW-1:0] r;
    logic [D-1:0] ne, no;
    int sh;
    sh = sa % SRC_W;
    r = '0;
    for (int k = 0; k < LANES; k++) begin
      ne = ref_lane(e[k*SRC_W +: SRC_W], ss, ds, sat, rnd, sh);
      no = ref_lane(o[k*SRC_W +: SRC_W], ss, ds, sat, rnd, sh);
      if (shuf) begin
        r[(2*k)*D +: D]   = ne;
        r[(2*k+1)*D +: D] = no;
      end else begin
        r[k*D +: D]         = ne;
        r[(LANES+k)*D +: D] = no;
      end
    end
    return r;
  endfunction

  // Reference pipeline
  logic m1_v, m2_v;
  logic [VW-1:0] m1_d, m2_d;
  string m1_t, m2_t;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1_v <= 0; m2_v <= 0; m1_d <= '0; m2_d <= '0; m1_t <= "R1"; m2_t <= "R1";
    end else begin
      m1_v <= vld_in;
      m1_d <= ref_out(odd_in, even_in, int'(shamt), src_signed, dst_signed,
                      sat_en, rnd_en, shuf_en);
      m1_t <= cur_tag;
      m2_v <= m1_v;
      if (m1_v) begin m2_d <= m1_d; m2_t <= m1_t; end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      total++;
      if (vld_out !== m2_v) begin
        bad++;
        $display("FAIL R2 vld_out actual=%0b expected=%0b", vld_out, m2_v);
      end
      total++;
      if (dout !== m2_d) begin
        bad++;
        $display("FAIL %s dout actual=%h expected=%h", m2_v ? m2_t : "R2", dout, m2_d);
      end
    end
  end

  task automatic send(logic [VW-1:0] o, logic [VW-1:0] e, int sa, bit ss, bit ds,
                      bit sat, bit rnd, bit shuf, string tag);
    @(negedge clk);
    vld_in = 1; odd_in = o; even_in = e; shamt = 8'(sa);
    src_signed = ss; dst_signed = ds; sat_en = sat; rnd_en = rnd; shuf_en = shuf;
    cur_tag = tag;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vld_in = 0; odd_in = ~odd_in; even_in = {even_in[VW-2:0], even_in[VW-1]};
      shamt = shamt + 8'd3; shuf_en = ~shuf_en; sat_en = ~sat_en;
    end
  endtask

  logic [VW-1:0] ramp_o, ramp_e;

  initial begin
    for (int k = 0; k < LANES; k++) begin
      ramp_e[k*SRC_W +: SRC_W] = 32'h1234_0000 + 32'(k * 32'h0101_0101);
      ramp_o[k*SRC_W +: SRC_W] = 32'h8765_4321 - 32'(k * 32'h0011_2233);
    end
    repeat (3) @(negedge clk);
    // R1: reset state observed by the per-cycle compare
    rst_n = 1;
    idle(2);
    // R4 R9: truncation, interleaved
    send(ramp_o, ramp_e, 4, 1, 1, 0, 0, 1, "R4");
    // R10: split layout, back to back
    send(ramp_o, ramp_e, 0, 0, 0, 0, 0, 0, "R10");
    send(ramp_o, ramp_e, 8, 1, 0, 0, 0, 1, "R9");
    idle(3);
    // R3: shift modulo width, arithmetic vs logical
    send(ramp_o, ramp_e, SRC_W + 12, 1, 1, 0, 0, 1, "R3");
    send(ramp_o, ramp_e, SRC_W + 12, 0, 0, 0, 0, 1, "R3");
    send({LANES{32'h8000_0000}}, {LANES{32'hF000_0000}}, 20, 1, 1, 0, 0, 0, "R3");
    idle(2);
    // R5: saturation signed and unsigned destinations
    send({LANES{32'h7FFF_FFFF}}, {LANES{32'h8000_0000}}, 2, 1, 1, 1, 0, 1, "R5");
    send({LANES{32'h0000_7FFF}}, {LANES{32'hFFFF_8000}}, 0, 1, 1, 1, 0, 1, "R5");
    send({LANES{32'h0001_2345}}, {LANES{32'hFFFF_FFFF}}, 0, 1, 0, 1, 0, 0, "R5");
    idle(2);
    // R6: unsigned source ignores dst_signed
    send({LANES{32'hFFFF_0000}}, {LANES{32'h0000_9000}}, 0, 0, 1, 1, 0, 1, "R6");
    idle(2);
    // R7: rounding, including carry past the source width
    send({LANES{32'h0000_0003}}, {LANES{32'h0000_0005}}, 1, 1, 1, 1, 1, 1, "R7");
    send({LANES{32'hFFFF_FFFF}}, {LANES{32'hFFFF_FFFF}}, 1, 0, 0, 1, 1, 1, "R7");
    send({LANES{32'h7FFF_FFFF}}, {LANES{32'hFFFF_FFFD}}, 1, 1, 1, 1, 1, 0, "R7");
    send({LANES{32'h0001_8000}}, {LANES{32'h0000_00FF}}, 0, 1, 1, 1, 1, 1, "R7");
    idle(2);
    // R8: rounding ignored without saturation
    send({LANES{32'h0000_0003}}, {LANES{32'h0003_FFFF}}, 2, 1, 1, 0, 1, 1, "R8");
    idle(2);
    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [VW-1:0] ro, re;
      for (int k = 0; k < VW / 32; k++) begin
        ro[k*32 +: 32] = $urandom;
        re[k*32 +: 32] = $urandom;
      end
      send(ro, re, int'($urandom_range(0, 70)), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom), "R5");
      if ($urandom_range(0, 3) == 0) idle(1);
    end
    idle(4);
    // R1: reset mid-stream clears output
    send(ramp_o, ramp_e, 1, 1, 1, 0, 0, 1, "R1");
    @(negedge clk);
    vld_in = 0;
    rst_n = 0;
    idle(2);
    rst_n = 1;
    idle(3);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule